// File: doc/BRIEF.md
# Card Contact Power Sequencer

This block brings up and tears down the supply and signal contacts of a smart card in a fixed, safe order. A single control level, `supply_req`, asks for a card session. When it rises while a card sits in the slot and the supply is healthy, the sequencer first switches on the step-up converter. It then enables the card supply, releases the I/O line, starts the card clock and finally lifts the card reset. Each step waits a programmable number of ticks. The ticks come from a divider on the block clock, which stands for the internal oscillator. Dropping `supply_req` walks the same contacts back down in reverse order.

During a session, three events force an emergency shutdown without any help from software: the card leaves the slot, the supply alarm fires, or the overcurrent flag rises. The sequencer latches the fault and drops `status_on`, which also tracks card presence. If enabled, it raises `irq`. The controller must take `supply_req` low before a new session can start. Every change of `status_on` sets `irq` while interrupts are enabled, and `irq` stays set until `irq_clr` is pulsed.

Top module: `card_pwr_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, all five contact outputs, `status_on` and `irq` are 0.
- R2: `boost_en` rises only on the clock edge after a cycle in which `supply_req`=1, `card_present`=1, `supply_alarm`=0 and `overcurrent`=0 with no fault latched; under any other input combination all contacts stay 0.
- R3: Activation order is `boost_en`, `vcc_en`, `io_rel`, `clk_rel`, `rst_rel`. With D=`TICK_DIV` and S=`STEP_TICKS`, the first gap lasts between (S-1)·D+1 and S·D cycles, and each later gap lasts exactly S·D cycles, so `rst_rel` rises at most 4·S·D+1 cycles after the request.
- R4: The contacts nest at all times: `vcc_en` implies `boost_en`, `io_rel` implies `vcc_en`, `clk_rel` implies `io_rel`, and `rst_rel` implies `clk_rel`.
- R5: A fall of `supply_req` in a live session drops `rst_rel` on the next edge. Then `clk_rel` falls after a first gap of (S-1)·D+1 to S·D cycles, and `io_rel`, `vcc_en` and `boost_en` follow, each exactly S·D cycles after the one before.
- R6: A fall of `supply_req` at any point of activation starts deactivation at once; all contacts are 0 within 4·S·D+1 cycles and `boost_en` falls last.
- R7: A fault (`card_present`=0, `supply_alarm`=1 or `overcurrent`=1) while any contact is on drops `rst_rel` on the next edge and runs the full deactivation.
- R8: After a fault shutdown, the block does not reactivate while `supply_req` stays 1; once `supply_req` has been 0 for a cycle, a new request is accepted.
- R9: `status_on` equals, one cycle late, `card_present` AND NOT (fault latched); a fault drops it on the edge that drops `rst_rel`.
- R10: `irq` is set on the edge where `status_on` changes if `irq_en` was 1 in the cycle before that edge. It is cleared by `irq_clr`=1 only; a set in the same cycle wins over the clear, and with `irq_en`=0 a change of status leaves `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock (oscillator) |
| rst_n | input | 1 | asynchronous reset, active low |
| supply_req | input | 1 | session request level |
| card_present | input | 1 | card in slot, active high |
| supply_alarm | input | 1 | supply supervisor alarm, active high |
| overcurrent | input | 1 | card supply overcurrent flag |
| irq_en | input | 1 | enables interrupt on status change |
| irq_clr | input | 1 | clears the interrupt |
| boost_en | output | 1 | step-up converter enable |
| vcc_en | output | 1 | card supply enable |
| io_rel | output | 1 | I/O contact released |
| clk_rel | output | 1 | card clock running |
| rst_rel | output | 1 | card reset released (high) |
| status_on | output | 1 | card present and no latched fault |
| irq | output | 1 | interrupt to the controller |

## Verification
The bench builds the block with `TICK_DIV`=2 and `STEP_TICKS`=3, which makes one step six cycles and a full sequence a few dozen cycles. At that size, the bench can sweep every phase of the request against the tick divider, and so exercise both ends of the first-gap window. It can also try all eight combinations of presence, alarm and overcurrent at request time, abort after each of the four activation stages, and inject each of the three fault kinds into a live session.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;
  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_UP_BOOST,
    SQ_UP_VCC,
    SQ_UP_IO,
    SQ_UP_CLK,
    SQ_LIVE,
    SQ_DN_RST,
    SQ_DN_CLK,
    SQ_DN_IO,
    SQ_DN_VCC
  } seq_state_e;

  localparam int NUM_CONTACTS = 5;
  localparam int CT_BOOST = 0;
  localparam int CT_VCC   = 1;
  localparam int CT_IO    = 2;
  localparam int CT_CLK   = 3;
  localparam int CT_RST   = 4;
endpackage

// File: rtl/seq_tick_gen.sv
module seq_tick_gen #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import card_seq_pkg::*;
#(
  parameter int STEP = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    req,
  input  logic                    present,
  input  logic                    alarm,
  input  logic                    ovc,
  output logic [NUM_CONTACTS-1:0] contacts,
  output logic                    fault_d
);
  localparam int SW = $clog2(STEP + 1);

  seq_state_e             st_q, st_d;
  logic [SW-1:0]          cnt_q;
  logic [NUM_CONTACTS-1:0] ct_q, ct_d;
  logic                   fault_q;
  logic                   hazard, in_up, step_done;

  assign hazard    = alarm | ovc | ~present;
  assign step_done = tick && (cnt_q == SW'(STEP - 1));
  assign in_up     = (st_q == SQ_UP_BOOST) || (st_q == SQ_UP_VCC) ||
                     (st_q == SQ_UP_IO) || (st_q == SQ_UP_CLK) || (st_q == SQ_LIVE);

  always_comb begin
    st_d = st_q;
    ct_d = ct_q;
    unique case (st_q)
      SQ_IDLE:     if (req && !hazard && !fault_q) begin st_d = SQ_UP_BOOST; ct_d[CT_BOOST] = 1'b1; end
      SQ_UP_BOOST: if (step_done) begin st_d = SQ_UP_VCC; ct_d[CT_VCC] = 1'b1; end
      SQ_UP_VCC:   if (step_done) begin st_d = SQ_UP_IO;  ct_d[CT_IO]  = 1'b1; end
      SQ_UP_IO:    if (step_done) begin st_d = SQ_UP_CLK; ct_d[CT_CLK] = 1'b1; end
      SQ_UP_CLK:   if (step_done) begin st_d = SQ_LIVE;   ct_d[CT_RST] = 1'b1; end
      SQ_LIVE:     ;
      SQ_DN_RST:   if (step_done) begin st_d = SQ_DN_CLK; ct_d[CT_CLK] = 1'b0; end
      SQ_DN_CLK:   if (step_done) begin st_d = SQ_DN_IO;  ct_d[CT_IO]  = 1'b0; end
      SQ_DN_IO:    if (step_done) begin st_d = SQ_DN_VCC; ct_d[CT_VCC] = 1'b0; end
      SQ_DN_VCC:   if (step_done) begin st_d = SQ_IDLE;   ct_d[CT_BOOST] = 1'b0; end
      default:     st_d = SQ_IDLE;
    endcase
    if (in_up && (hazard || !req)) begin
      st_d = SQ_DN_RST;
      ct_d[CT_RST] = 1'b0;
    end
  end

  always_comb begin
    if (in_up && hazard) fault_d = 1'b1;
    else if (!req)       fault_d = 1'b0;
    else                 fault_d = fault_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      cnt_q   <= '0;
      ct_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ct_q    <= ct_d;
      fault_q <= fault_d;
      if (st_d != st_q) cnt_q <= '0;
      else if (tick)    cnt_q <= cnt_q + 1'b1;
    end
  end

  assign contacts = ct_q;
endmodule

// File: rtl/seq_status_irq.sv
module seq_status_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic present,
  input  logic fault_d,
  input  logic irq_en,
  input  logic irq_clr,
  output logic status,
  output logic irq
);
  logic status_q, irq_q, status_d;

  assign status_d = present & ~fault_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      if (irq_en && (status_d != status_q)) irq_q <= 1'b1;
      else if (irq_clr)                     irq_q <= 1'b0;
    end
  end

  assign status = status_q;
  assign irq    = irq_q;
endmodule

// File: rtl/card_pwr_seq.sv
module card_pwr_seq
  import card_seq_pkg::*;
#(
  parameter int TICK_DIV   = 16,
  parameter int STEP_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_req,
  input  logic card_present,
  input  logic supply_alarm,
  input  logic overcurrent,
  input  logic irq_en,
  input  logic irq_clr,
  output logic boost_en,
  output logic vcc_en,
  output logic io_rel,
  output logic clk_rel,
  output logic rst_rel,
  output logic status_on,
  output logic irq
);
  logic                    tick;
  logic                    fault_d;
  logic [NUM_CONTACTS-1:0] contacts;

  seq_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  seq_fsm #(.STEP(STEP_TICKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req(supply_req), .present(card_present), .alarm(supply_alarm), .ovc(overcurrent),
    .contacts(contacts), .fault_d(fault_d)
  );

  seq_status_irq u_stat (
    .clk(clk), .rst_n(rst_n), .present(card_present), .fault_d(fault_d),
    .irq_en(irq_en), .irq_clr(irq_clr), .status(status_on), .irq(irq)
  );

  assign boost_en = contacts[CT_BOOST];
  assign vcc_en   = contacts[CT_VCC];
  assign io_rel   = contacts[CT_IO];
  assign clk_rel  = contacts[CT_CLK];
  assign rst_rel  = contacts[CT_RST];
endmodule

// File: rtl/card_pwr_seq_chk.sv
module card_pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_req,
  input logic card_present,
  input logic supply_alarm,
  input logic overcurrent,
  input logic irq_en,
  input logic boost_en,
  input logic vcc_en,
  input logic io_rel,
  input logic clk_rel,
  input logic rst_rel,
  input logic status_on,
  input logic irq
);
  a_r4_nesting: assert property (@(posedge clk) disable iff (!rst_n)
    (!vcc_en || boost_en) && (!io_rel || vcc_en) && (!clk_rel || io_rel) && (!rst_rel || clk_rel));

  a_r2_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boost_en) |-> $past(supply_req && card_present && !supply_alarm && !overcurrent));

  a_r5_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_rel && !supply_req) |=> !rst_rel);

  a_r7_fault_drops_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_rel && (supply_alarm || overcurrent || !card_present)) |=> !rst_rel);

  a_r9_fault_drops_status: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_rel && (supply_alarm || overcurrent)) |=> !status_on);

  a_r10_irq_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_en) && (status_on != $past(status_on))) |-> irq);
endmodule

bind card_pwr_seq card_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_req(supply_req), .card_present(card_present),
  .supply_alarm(supply_alarm), .overcurrent(overcurrent), .irq_en(irq_en),
  .boost_en(boost_en), .vcc_en(vcc_en), .io_rel(io_rel), .clk_rel(clk_rel),
  .rst_rel(rst_rel), .status_on(status_on), .irq(irq)
);

// File: tb/test_card_pwr_seq.sv
module test_card_pwr_seq;
  localparam int D  = 2;
  localparam int S  = 3;
  localparam int SD = S * D;
  localparam int BOUND = 4 * SD + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_req = 1'b0, card_present = 1'b1, supply_alarm = 1'b0, overcurrent = 1'b0;
  logic irq_en = 1'b0, irq_clr = 1'b0;
  logic boost_en, vcc_en, io_rel, clk_rel, rst_rel, status_on, irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t_up[5];
  int t_dn[5];
  logic [4:0] prev = '0;
  logic [4:0] outs;

  always #2 clk = ~clk;

  card_pwr_seq #(.TICK_DIV(D), .STEP_TICKS(S)) i_card_pwr_seq (
    .clk(clk), .rst_n(rst_n), .supply_req(supply_req), .card_present(card_present),
    .supply_alarm(supply_alarm), .overcurrent(overcurrent), .irq_en(irq_en),
    .irq_clr(irq_clr), .boost_en(boost_en), .vcc_en(vcc_en), .io_rel(io_rel),
    .clk_rel(clk_rel), .rst_rel(rst_rel), .status_on(status_on), .irq(irq)
  );

  assign outs = {rst_rel, clk_rel, io_rel, vcc_en, boost_en};

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int i = 0; i < 5; i++) begin
      if (outs[i] && !prev[i]) t_up[i] = cyc;
      if (!outs[i] && prev[i]) t_dn[i] = cyc;
    end
    prev = outs;
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_times();
    for (int i = 0; i < 5; i++) begin t_up[i] = -1; t_dn[i] = -1; end
  endtask

  task automatic wait_all_off(input int t0, input string tag);
    for (int n = 0; n < 3 * BOUND && outs != 0; n++) step();
    chk(outs == 0 && (cyc - t0) <= BOUND, tag, cyc - t0, BOUND);
  endtask

  task automatic activate(input int t0v);
    int t0;
    clear_times();
    supply_req = 1'b1;
    t0 = cyc;
    for (int n = 0; n < 3 * BOUND && !rst_rel; n++) step();
    chk(t_up[0] == t0 + 1, "R2 boost edge", t_up[0] - t0, 1);
    chk(t_up[1] - t_up[0] >= (S-1)*D+1 && t_up[1] - t_up[0] <= SD, "R3 first gap", t_up[1] - t_up[0], SD);
    chk(t_up[2] - t_up[1] == SD, "R3 io gap", t_up[2] - t_up[1], SD);
    chk(t_up[3] - t_up[2] == SD, "R3 clk gap", t_up[3] - t_up[2], SD);
    chk(t_up[4] - t_up[3] == SD, "R3 rst gap", t_up[4] - t_up[3], SD);
    chk(t_up[4] - t0 <= BOUND, "R3 total", t_up[4] - t0, BOUND);
    if (t0v < 0) chk(1'b1, "R3", 0, 0);
  endtask

  task automatic deactivate_normal();
    int t0;
    clear_times();
    supply_req = 1'b0;
    t0 = cyc;
    for (int n = 0; n < 3 * BOUND && boost_en; n++) step();
    chk(t_dn[4] == t0 + 1, "R5 reset first", t_dn[4] - t0, 1);
    chk(t_dn[3] - t_dn[4] >= (S-1)*D+1 && t_dn[3] - t_dn[4] <= SD, "R5 clk gap", t_dn[3] - t_dn[4], SD);
    chk(t_dn[2] - t_dn[3] == SD, "R5 io gap", t_dn[2] - t_dn[3], SD);
    chk(t_dn[1] - t_dn[2] == SD, "R5 vcc gap", t_dn[1] - t_dn[2], SD);
    chk(t_dn[0] - t_dn[1] == SD, "R5 boost gap", t_dn[0] - t_dn[1], SD);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    clear_times();
    step();
    chk(outs == 0 && !status_on && !irq, "R1 in reset", {outs, status_on, irq}, 0);
    rst_n = 1'b1;
    step();
    chk(outs == 0, "R1 after reset", outs, 0);
    step();
    chk(status_on == 1'b1, "R9 present idle", status_on, 1);
    chk(irq == 1'b0, "R10 disabled no irq", irq, 0);

    // R2: sweep all hazard combinations that must block activation
    for (int c = 1; c < 8; c++) begin
      card_present = !c[0];
      supply_alarm = c[1];
      overcurrent  = c[2];
      supply_req = 1'b1;
      for (int n = 0; n < 2 * SD; n++) step();
      chk(boost_en == 1'b0, "R2 blocked", c, 0);
      supply_req = 1'b0;
      step();
    end
    card_present = 1'b1; supply_alarm = 1'b0; overcurrent = 1'b0;
    step();

    // R3/R5: sweep request phase against the divider
    for (int p = 0; p < 2 * D; p++) begin
      for (int n = 0; n < p; n++) step();
      activate(p);
      chk(outs == 5'h1f, "R4 all up", outs, 31);
      step();
      deactivate_normal();
      step();
    end

    // R6: abort after each activation stage
    for (int k = 1; k <= 4; k++) begin
      int t0;
      clear_times();
      supply_req = 1'b1;
      for (int n = 0; n < 3 * BOUND && $countones(outs) < k; n++) step();
      supply_req = 1'b0;
      t0 = cyc;
      wait_all_off(t0, "R6 abort off");
      chk(t_dn[0] >= t_dn[k-1], "R6 boost last", t_dn[0], t_dn[k-1]);
      step();
    end

    // R7/R8/R9/R10: each fault kind in a live session
    irq_en = 1'b1;
    for (int f = 0; f < 3; f++) begin
      int t0;
      activate(f);
      irq_clr = 1'b1; step(); irq_clr = 1'b0;
      chk(irq == 1'b0, "R10 cleared", irq, 0);
      if (f == 0) card_present = 1'b0;
      if (f == 1) supply_alarm = 1'b1;
      if (f == 2) overcurrent = 1'b1;
      t0 = cyc;
      step();
      chk(rst_rel == 1'b0, "R7 reset drops", rst_rel, 0);
      chk(status_on == 1'b0, "R9 status drops", status_on, 0);
      chk(irq == 1'b1, "R10 fault irq", irq, 1);
      card_present = 1'b1; supply_alarm = 1'b0; overcurrent = 1'b0;
      wait_all_off(t0, "R7 shutdown");
      for (int n = 0; n < 2 * SD; n++) step();
      chk(boost_en == 1'b0, "R8 no restart", boost_en, 0);
      chk(status_on == 1'b0, "R9 fault held", status_on, 0);
      supply_req = 1'b0;
      step();
      step();
      chk(status_on == 1'b1, "R9 fault released", status_on, 1);
      activate(f);
      chk(rst_rel == 1'b1, "R8 restart ok", rst_rel, 1);
      deactivate_normal();
      step();
    end

    // R10: set wins over clear, clear alone, disabled
    card_present = 1'b0; irq_clr = 1'b1;
    step();
    irq_clr = 1'b0;
    chk(irq == 1'b1, "R10 set wins", irq, 1);
    irq_clr = 1'b1; step(); irq_clr = 1'b0;
    chk(irq == 1'b0, "R10 clear", irq, 0);
    irq_en = 1'b0;
    card_present = 1'b1;
    step(); step();
    chk(status_on == 1'b1, "R9 reinsert", status_on, 1);
    chk(irq == 1'b0, "R10 disabled", irq, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule